// File: doc/BRIEF.md
# Stepwise Operating-Mode Sequencer

This block moves a low-power subsystem between four operating modes. It exchanges a request and an acknowledge with an external power manager. Software writes a target mode. The sequencer then moves its request output toward that target one mode at a time along a fixed chain. Before each further hop it waits until the power manager reports that the current request has been reached. The mode the power manager reports is registered and published as the current mode. Software and the controlled engine must treat this acknowledged value, and not the requested one, as the mode in force.

Each requested mode also implies a supply-state request. The two powerdown modes ask for the low-current supply, and the other two ask for the full supply. A restricted output tells the engine that the acknowledged mode is a low-current one, so that peripherals which need full current must not be used.

The control core is a two-state machine:
- `SEQ_IDLE` is left for `SEQ_WAIT_ACK` on the "issue hop" transition, taken when the request differs from the target. On that edge the request moves one step toward the target.
- `SEQ_WAIT_ACK` returns to `SEQ_IDLE` on the "hop acknowledged" transition, taken when the registered acknowledged mode equals the request.
- `SEQ_IDLE` holds itself on "settled", when the request equals the target.
- `SEQ_WAIT_ACK` holds itself on "awaiting", when the acknowledge does not yet match.

Top module: `opmode_stepper`

## Requirements
- R1: After reset the request, the current mode and the target all hold the active code 1. Busy, the supply-low request and restricted are all 0.
- R2: Modes are encoded as 0 = powerdown-active, 1 = active, 2 = low-power and 3 = powerdown-low-power. The request only ever changes by +1 or -1, so it never skips a mode and never wraps between 3 and 0.
- R3: Once the request differs from the current (acknowledged) mode, the request holds its value until the current mode equals it.
- R4: While the request differs from the target and the last hop is acknowledged, the block issues the next hop toward the target. It stops when the request equals the target. A write to the target takes effect on the next clock edge. The first hop follows one edge later.
- R5: The current-mode output equals the power manager's acknowledge input, delayed by exactly one clock.
- R6: The supply-low request is 1 exactly when the requested mode is 0 or 3.
- R7: Restricted is 1 exactly when the current mode is 0 or 3.
- R8: Busy is 1 exactly when the request differs from the current mode or from the target.
- R9: When a new target is written while a hop is still unacknowledged, the pending request is kept until it is acknowledged. Stepping then continues toward the new target.
- R10: Writing a target equal to the settled mode causes no request change, and busy stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tgt_wr | input | 1 | Target write strobe |
| tgt_mode | input | 2 | Target mode code written on the strobe |
| pm_ack_mode | input | 2 | Mode that the power manager reports as reached |
| pm_req_mode | output | 2 | Mode requested from the power manager |
| supply_low_req | output | 1 | Request for the low-current supply state |
| restricted | output | 1 | Acknowledged mode is a low-current mode |
| busy | output | 1 | A transition is pending or in flight |
| cur_mode | output | 2 | Acknowledged (current) mode |

## Verification
The bench records every value the request takes.

- **Full-span moves (R2, R4).** A design that jumps straight to the target, or wraps from 3 to 0, leaves a wrong hop sequence in the record.
- **Stalled acknowledge (R3, R5, R7).** With the acknowledge held back, the bench checks that the request stays put and that the current mode lags the request. It also checks that restricted follows the acknowledged mode and not the requested one. A design that reads the request as the current mode would flag restricted too early.
- **Retarget mid-hop (R9).** The target is rewritten during a hop. A design that drops the in-flight request would show a hop that was never acknowledged.
- **Self-target write (R10).** Writing the settled mode as the target catches a design that pulses busy or issues a spurious request.

// File: rtl/opmode_pkg.sv
package opmode_pkg;

    localparam int MODE_W = 2;
    localparam logic [MODE_W-1:0] MODE_ONE = {{(MODE_W-1){1'b0}}, 1'b1};

    // Chain order: adjacent codes are adjacent modes.
    typedef enum logic [MODE_W-1:0] {
        MODE_PD_ACT = 2'd0,
        MODE_ACT    = 2'd1,
        MODE_LP     = 2'd2,
        MODE_PD_LP  = 2'd3
    } mode_e;

    typedef enum logic {
        SEQ_IDLE     = 1'b0,
        SEQ_WAIT_ACK = 1'b1
    } seq_state_e;

    localparam mode_e RESET_MODE = MODE_ACT;

    function automatic logic mode_is_lowcur(mode_e m);
        return (m == MODE_PD_ACT) || (m == MODE_PD_LP);
    endfunction

endpackage

// File: rtl/opmode_target_reg.sv
module opmode_target_reg
    import opmode_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  mode_e wr_mode,
    output mode_e target
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            target <= RESET_MODE;
        end else if (wr_en) begin
            target <= wr_mode;
        end
    end

endmodule

// File: rtl/opmode_ack_capture.sv
module opmode_ack_capture
    import opmode_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  mode_e ack_in,
    output mode_e cur
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur <= RESET_MODE;
        end else begin
            cur <= ack_in;
        end
    end

endmodule

// File: rtl/opmode_step_calc.sv
module opmode_step_calc
    import opmode_pkg::*;
(
    input  mode_e req,
    input  mode_e target,
    output logic  need_step,
    output mode_e step_mode
);

    logic [MODE_W-1:0] up_code;
    logic [MODE_W-1:0] dn_code;

    assign up_code   = req + MODE_ONE;
    assign dn_code   = req - MODE_ONE;
    assign need_step = (req != target);
    assign step_mode = (target > req) ? mode_e'(up_code) : mode_e'(dn_code);

endmodule

// File: rtl/opmode_seq_fsm.sv
module opmode_seq_fsm
    import opmode_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  need_step,
    input  mode_e step_mode,
    input  mode_e cur,
    output mode_e req,
    output seq_state_e state
);

    seq_state_e state_nx;
    logic       hop_acked;
    logic       issue_hop;

    assign hop_acked = (cur == req);
    assign issue_hop = (state == SEQ_IDLE) && need_step;

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            SEQ_IDLE: begin
                if (need_step) begin
                    state_nx = SEQ_WAIT_ACK;   // issue hop
                end
            end
            SEQ_WAIT_ACK: begin
                if (hop_acked) begin
                    state_nx = SEQ_IDLE;       // hop acknowledged
                end
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Output register: the request moves only on an issued hop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req <= RESET_MODE;
        end else if (issue_hop) begin
            req <= step_mode;
        end
    end

endmodule

// File: rtl/opmode_stepper.sv
module opmode_stepper
    import opmode_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tgt_wr,
    input  logic [MODE_W-1:0] tgt_mode,
    input  logic [MODE_W-1:0] pm_ack_mode,
    output logic [MODE_W-1:0] pm_req_mode,
    output logic              supply_low_req,
    output logic              restricted,
    output logic              busy,
    output logic [MODE_W-1:0] cur_mode
);

    mode_e      target_q;
    mode_e      cur_q;
    mode_e      req_q;
    mode_e      step_mode;
    logic       need_step;
    seq_state_e seq_state;

    opmode_target_reg u_target (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tgt_wr),
        .wr_mode (mode_e'(tgt_mode)),
        .target  (target_q)
    );

    opmode_ack_capture u_ack (
        .clk    (clk),
        .rst_n  (rst_n),
        .ack_in (mode_e'(pm_ack_mode)),
        .cur    (cur_q)
    );

    opmode_step_calc u_step (
        .req       (req_q),
        .target    (target_q),
        .need_step (need_step),
        .step_mode (step_mode)
    );

    opmode_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .need_step (need_step),
        .step_mode (step_mode),
        .cur       (cur_q),
        .req       (req_q),
        .state     (seq_state)
    );

    assign pm_req_mode    = req_q;
    assign cur_mode       = cur_q;
    assign supply_low_req = mode_is_lowcur(req_q);
    assign restricted     = mode_is_lowcur(cur_q);
    assign busy           = (req_q != cur_q) || (req_q != target_q);

endmodule

// File: rtl/opmode_stepper_chk.sv
module opmode_stepper_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] ack_in,
    input logic [1:0] req,
    input logic [1:0] cur,
    input logic       supply_low,
    input logic       restricted,
    input logic       busy
);

    AST_SINGLE_HOP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(req) |-> (({1'b0, req} == {1'b0, $past(req)} + 3'd1) ||
                           ({1'b0, $past(req)} == {1'b0, req} + 3'd1))); // R2

    AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (req != cur) |=> $stable(req)); // R3

    AST_SETTLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(req)); // R10

    AST_CUR_TRACKS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cur == $past(ack_in))); // R5

    AST_SUPPLY_LOW_MODES: assert property (@(posedge clk) disable iff (!rst_n)
        supply_low |-> (req == 2'd0 || req == 2'd3)); // R6

    AST_RESTRICTED_MODES: assert property (@(posedge clk) disable iff (!rst_n)
        (cur == 2'd1 || cur == 2'd2) |-> !restricted); // R7

    AST_BUSY_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (req != cur) |-> busy); // R8

endmodule

bind opmode_stepper opmode_stepper_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ack_in     (pm_ack_mode),
    .req        (pm_req_mode),
    .cur        (cur_mode),
    .supply_low (supply_low_req),
    .restricted (restricted),
    .busy       (busy)
);

// File: tb/sim_opmode_stepper.sv
`timescale 1ns/1ps
module sim_opmode_stepper;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tgt_wr = 1'b0;
    logic [1:0] tgt_mode = 2'd1;
    logic [1:0] pm_ack_mode = 2'd1;
    logic [1:0] pm_req_mode;
    logic       supply_low_req;
    logic       restricted;
    logic       busy;
    logic [1:0] cur_mode;

    int n_tests = 0;
    int n_fail  = 0;
    int ack_delay = 2;
    bit pm_en = 1'b1;
    bit done = 1'b0;

    logic [1:0] hop_log [0:15];
    int hop_n = 0;
    int viol_step = 0;
    int viol_hold = 0;

    always #4 clk = ~clk;

    opmode_stepper u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .tgt_wr         (tgt_wr),
        .tgt_mode       (tgt_mode),
        .pm_ack_mode    (pm_ack_mode),
        .pm_req_mode    (pm_req_mode),
        .supply_low_req (supply_low_req),
        .restricted     (restricted),
        .busy           (busy),
        .cur_mode       (cur_mode)
    );

    // Power-manager model: acknowledges the request after ack_delay cycles
    initial begin : pm_model
        int cnt;
        cnt = 0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                pm_ack_mode = 2'd1;
                cnt = 0;
            end else if (pm_en && pm_ack_mode != pm_req_mode) begin
                cnt++;
                if (cnt >= ack_delay) begin
                    pm_ack_mode = pm_req_mode;
                    cnt = 0;
                end
            end else begin
                cnt = 0;
            end
        end
    end

    // Request monitor: logs hops, counts skipped modes and unacknowledged changes
    initial begin : req_monitor
        logic [1:0] prev_req;
        logic [1:0] prev_cur;
        prev_req = 2'd1;
        prev_cur = 2'd1;
        forever begin
            @(negedge clk);
            if (rst_n && pm_req_mode != prev_req) begin
                if (!((int'(pm_req_mode) == int'(prev_req) + 1) ||
                      (int'(pm_req_mode) + 1 == int'(prev_req))))
                    viol_step++;
                if (prev_req != prev_cur)
                    viol_hold++;
                if (hop_n < 16) hop_log[hop_n] = pm_req_mode;
                hop_n++;
            end
            prev_req = pm_req_mode;
            prev_cur = cur_mode;
        end
    end

    task automatic check_eq(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic expect_hops(string tag, int n, int h0, int h1 = 0, int h2 = 0);
        int exp_h [3];
        exp_h[0] = h0; exp_h[1] = h1; exp_h[2] = h2;
        check_eq({tag, " hop count"}, hop_n, n);
        for (int i = 0; i < n && i < 3 && i < hop_n; i++)
            check_eq({tag, " hop value"}, int'(hop_log[i]), exp_h[i]);
    endtask

    task automatic write_target(logic [1:0] m);
        @(negedge clk);
        tgt_wr = 1'b1;
        tgt_mode = m;
        @(negedge clk);
        tgt_wr = 1'b0;
    endtask

    task automatic wait_settle();
        for (int i = 0; i < 200; i++) begin
            if (!busy) break;
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    task automatic t_reset();
        check_eq("R1 request", int'(pm_req_mode), 1);
        check_eq("R1 current", int'(cur_mode), 1);
        check_eq("R1 busy", int'(busy), 0);
        check_eq("R1 supply low", int'(supply_low_req), 0);
        check_eq("R1 restricted", int'(restricted), 0);
    endtask

    task automatic t_climb();
        hop_n = 0;
        ack_delay = 3;
        write_target(2'd3);
        check_eq("R8 busy after write", int'(busy), 1);
        wait_settle();
        expect_hops("R4 R2 climb 1->3", 2, 2, 3);
        check_eq("R4 current at 3", int'(cur_mode), 3);
        check_eq("R7 restricted at 3", int'(restricted), 1);
        check_eq("R6 supply low at 3", int'(supply_low_req), 1);
        check_eq("R8 busy settled", int'(busy), 0);
    endtask

    task automatic t_descend();
        hop_n = 0;
        ack_delay = 1;
        write_target(2'd0);
        wait_settle();
        expect_hops("R4 R2 descend 3->0", 3, 2, 1, 0);
        check_eq("R4 current at 0", int'(cur_mode), 0);
    endtask

    task automatic t_ack_lag();
        hop_n = 0;
        pm_en = 1'b0;
        write_target(2'd1);
        @(negedge clk);
        check_eq("R4 request stepped", int'(pm_req_mode), 1);
        check_eq("R5 current lags", int'(cur_mode), 0);
        check_eq("R6 supply follows request", int'(supply_low_req), 0);
        check_eq("R7 restricted follows current", int'(restricted), 1);
        check_eq("R8 busy in flight", int'(busy), 1);
        repeat (4) @(negedge clk);
        check_eq("R3 request held", int'(pm_req_mode), 1);
        pm_ack_mode = 2'd1;
        check_eq("R5 no same-cycle update", int'(cur_mode), 0);
        @(negedge clk);
        check_eq("R5 one-cycle update", int'(cur_mode), 1);
        check_eq("R7 restricted cleared", int'(restricted), 0);
        pm_en = 1'b1;
        wait_settle();
        check_eq("R8 busy settled", int'(busy), 0);
    endtask

    task automatic t_retarget();
        hop_n = 0;
        pm_en = 1'b0;
        write_target(2'd3);
        @(negedge clk);
        check_eq("R9 first hop", int'(pm_req_mode), 2);
        write_target(2'd0);
        repeat (3) @(negedge clk);
        check_eq("R9 pending hop kept", int'(pm_req_mode), 2);
        pm_en = 1'b1;
        ack_delay = 2;
        wait_settle();
        expect_hops("R9 retarget path", 3, 2, 1, 0);
        check_eq("R9 final current", int'(cur_mode), 0);
    endtask

    task automatic t_same_target();
        int bad;
        bad = 0;
        hop_n = 0;
        write_target(2'd0);
        for (int i = 0; i < 6; i++) begin
            if (busy || pm_req_mode != 2'd0) bad++;
            @(negedge clk);
        end
        check_eq("R10 quiet samples", bad, 0);
        check_eq("R10 no hops", hop_n, 0);
    endtask

    task automatic t_full_span();
        hop_n = 0;
        ack_delay = 2;
        write_target(2'd3);
        wait_settle();
        expect_hops("R4 R2 span 0->3", 3, 1, 2, 3);
        hop_n = 0;
        write_target(2'd1);
        wait_settle();
        expect_hops("R4 R2 span 3->1", 2, 2, 1);
        check_eq("R2 no skipped modes", viol_step, 0);
        check_eq("R3 no unacknowledged changes", viol_hold, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_climb();
        t_descend();
        t_ack_lag();
        t_retarget();
        t_same_target();
        t_full_span();
        finish_run();
    end

endmodule